// File: doc/BRIEF.md
# Interlocked HV Pulse Sequencer

This block drives the eight logic-level control lines of one high-voltage pulser. A pulse set starts on a trigger. In one mode the trigger is the rising edge of an external single-bit input. In the other mode it comes from an internal timer whose period is never shorter than a clamped minimum. Each line gets its own start offset and length in clock cycles, both counted from the first cycle of the set. Line index 0 to 3 are RF control. Index 4 is discharge, index 5 is the first charge step, index 6 is the second charge step, and index 7 is spare.

A trouble input acts as an interlock. While it is high, every line is forced low at once. At the next edge the controller enters a latched fault state, and any set in progress is dropped. The fault holds until a clear input is pulsed while trouble is low. A trigger that arrives while a set is still running is not acted on, and it increments a saturating missed-trigger counter.

The controller has four states. IDLE waits for a trigger. RUN counts set cycles and drives the lines. DONE is a single cycle that raises the done strobe. FAULT is the latched interlock. The transitions are:
- IDLE to RUN on an accepted trigger.
- RUN to DONE when the cycle counter reaches the last cycle of the set.
- DONE to IDLE unconditionally.
- Any state to FAULT when trouble is high.
- FAULT to IDLE on a clear pulse while trouble is low.

Top module: `hvp_pulse_seq`

## Requirements
- R1: Cycle k = 0 is the first cycle after the clock edge that accepts a trigger. In cycle k, line i (bit i of `pulse_o`) is high exactly when `dly_i[i*CNT_W +: CNT_W]` <= k < that delay plus `wid_i[i*CNT_W +: CNT_W]`.
- R2: With `mode_int_i` low, each rising edge of `trig_ext_i` that is sampled in IDLE starts exactly one set. A pulse only one cycle wide is caught. A level held high does not start another set.
- R3: With `mode_int_i` high, sets start every P cycles, where P = max(`period_i`, MIN_PERIOD), and `trig_ext_i` has no effect.
- R4: With `two_step_i` low, line 6 (second charge step) stays low, and its timing does not lengthen the set.
- R5: While `trouble_i` is high, `pulse_o` and `busy_o` are 0 in the same cycle. At the next edge `fault_o` rises, and the aborted set produces no done strobe.
- R6: `fault_o` stays high until `fault_clr_i` is high at an edge while `trouble_i` is low. A clear while trouble is high, and any trigger during the fault, have no effect.
- R7: A trigger taken while in RUN or DONE starts no set and increments `missed_o`, which saturates at all ones.
- R8: `busy_o` is high for cycles k = 0 to E-1, where E = max(1, largest delay+width over enabled lines with nonzero width). `done_o` is high for exactly cycle k = E.
- R9: After reset, `pulse_o`, `busy_o`, `done_o`, `fault_o` and `missed_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_ext_i | input | 1 | External trigger; its rising edge starts a set |
| mode_int_i | input | 1 | 1 selects the internal periodic trigger |
| period_i | input | PER_W | Internal period in cycles, clamped to at least MIN_PERIOD |
| two_step_i | input | 1 | 1 enables the second charge step on line 6 |
| dly_i | input | N_OUT*CNT_W | Start delay of each line, packed with line i at i*CNT_W |
| wid_i | input | N_OUT*CNT_W | Width of each line, packed in the same way |
| trouble_i | input | 1 | Interlock request |
| fault_clr_i | input | 1 | Releases a latched fault while trouble is low |
| pulse_o | output | N_OUT | Control lines |
| busy_o | output | 1 | A set is running |
| done_o | output | 1 | One-cycle strobe after a set ends |
| fault_o | output | 1 | Latched fault |
| missed_o | output | MISS_W | Saturating count of ignored triggers |

## Verification
A trigger driven for one cycle is taken at the next edge. The bench then samples at the following falling edge as cycle k = 0 and compares every line, `busy_o` and `done_o` against a bench model in each cycle k = 0 to E. A rising `trouble_i` is checked one time step after it is driven, for the gated outputs. `fault_o` is checked one edge later. Internal mode is checked by counting cycles between consecutive rises of `busy_o`. `missed_o` is compared once the set that ignored the trigger has ended.

// File: rtl/hvp_pkg.sv
package hvp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DONE  = 2'd2,
        ST_FAULT = 2'd3
    } seq_state_e;
endpackage

// File: rtl/hvp_trig_src.sv
module hvp_trig_src #(
    parameter int PER_W      = 28,
    parameter int MIN_PERIOD = 1_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_ext_i,
    input  logic             mode_int_i,
    input  logic [PER_W-1:0] period_i,
    input  logic             hold_i,
    output logic             trig_o
);
    localparam logic [PER_W-1:0] MIN_P = PER_W'(MIN_PERIOD);

    logic             ext_q;
    logic [PER_W-1:0] tmr_q;
    logic [PER_W-1:0] eff_per;
    logic             tick;
    logic             ext_rise;

    assign eff_per  = (period_i < MIN_P) ? MIN_P : period_i;
    assign tick     = mode_int_i && (tmr_q == eff_per - 1'b1);
    assign ext_rise = trig_ext_i && !ext_q;
    assign trig_o   = mode_int_i ? tick : ext_rise;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= 1'b0;
            tmr_q <= '0;
        end else begin
            ext_q <= trig_ext_i;
            if (!mode_int_i || hold_i || tick) tmr_q <= '0;
            else                               tmr_q <= tmr_q + 1'b1;
        end
    end

    assert_min_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_int_i && !hold_i && tick) |=> !tick);
endmodule

// File: rtl/hvp_chan.sv
module hvp_chan #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W:0]   cnt_i,
    input  logic [CNT_W-1:0] dly_i,
    input  logic [CNT_W-1:0] wid_i,
    input  logic             en_i,
    input  logic             active_i,
    output logic             pulse_o,
    output logic [CNT_W:0]   end_o
);
    logic [CNT_W:0] stop;

    assign stop    = {1'b0, dly_i} + {1'b0, wid_i};
    assign pulse_o = active_i && en_i && (cnt_i >= {1'b0, dly_i}) && (cnt_i < stop);
    assign end_o   = (en_i && wid_i != '0) ? stop : '0;
endmodule

// File: rtl/hvp_pulse_seq.sv
module hvp_pulse_seq
    import hvp_pkg::*;
#(
    parameter int N_OUT      = 8,
    parameter int CNT_W      = 16,
    parameter int PER_W      = 28,
    parameter int MIN_PERIOD = 1_000_000,
    parameter int MISS_W     = 8,
    parameter int STEP2_IDX  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_ext_i,
    input  logic               mode_int_i,
    input  logic [PER_W-1:0]   period_i,
    input  logic               two_step_i,
    input  logic [N_OUT*CNT_W-1:0] dly_i,
    input  logic [N_OUT*CNT_W-1:0] wid_i,
    input  logic               trouble_i,
    input  logic               fault_clr_i,
    output logic [N_OUT-1:0]   pulse_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               fault_o,
    output logic [MISS_W-1:0]  missed_o
);
    localparam logic [MISS_W-1:0] MISS_MAX = '1;

    seq_state_e     state_q, state_d;
    logic [CNT_W:0] cnt_q, cnt_d;
    logic [CNT_W:0] set_end;
    logic [CNT_W:0] ch_end [N_OUT];
    logic [N_OUT-1:0] ch_pulse;
    logic           trig;
    logic           running;
    logic           in_fault;

    assign in_fault = (state_q == ST_FAULT) || trouble_i;
    assign running  = (state_q == ST_RUN) && !trouble_i;

    hvp_trig_src #(.PER_W(PER_W), .MIN_PERIOD(MIN_PERIOD)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_ext_i (trig_ext_i),
        .mode_int_i (mode_int_i),
        .period_i   (period_i),
        .hold_i     (in_fault),
        .trig_o     (trig)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_chan
        hvp_chan #(.CNT_W(CNT_W)) u_chan (
            .cnt_i    (cnt_q),
            .dly_i    (dly_i[i*CNT_W +: CNT_W]),
            .wid_i    (wid_i[i*CNT_W +: CNT_W]),
            .en_i     ((i == STEP2_IDX) ? two_step_i : 1'b1),
            .active_i (running),
            .pulse_o  (ch_pulse[i]),
            .end_o    (ch_end[i])
        );
    end

    always_comb begin
        set_end = '0;
        for (int i = 0; i < N_OUT; i++)
            if (ch_end[i] > set_end) set_end = ch_end[i];
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (trouble_i) begin
            state_d = ST_FAULT;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (trig) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end
                ST_RUN: begin
                    if (cnt_q + 1'b1 >= set_end) state_d = ST_DONE;
                    else                         cnt_d   = cnt_q + 1'b1;
                end
                ST_DONE:  state_d = ST_IDLE;
                ST_FAULT: if (fault_clr_i) state_d = ST_IDLE;
            endcase
        end
    end

    // State register and missed counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            missed_o <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (trig && !trouble_i && (state_q == ST_RUN || state_q == ST_DONE)
                && missed_o != MISS_MAX)
                missed_o <= missed_o + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        pulse_o = ch_pulse;
        busy_o  = running;
        done_o  = (state_q == ST_DONE) && !trouble_i;
        fault_o = (state_q == ST_FAULT);
    end

    assert_quiet_on_trouble_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trouble_i |-> (pulse_o == '0 && !busy_o));
    assert_fault_latches_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trouble_i |=> fault_o);
    assert_fault_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && !fault_clr_i) |=> fault_o);
    assert_step2_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !two_step_i |-> !pulse_o[STEP2_IDX]);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));
    assert_miss_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
        missed_o >= $past(missed_o));
endmodule

// File: tb/hvp_pulse_seq_tb.sv
module hvp_pulse_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_OUT  = 8;
    localparam int CNT_W  = 16;
    localparam int PER_W  = 28;
    localparam int MIN_P  = 40;
    localparam int MISS_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_ext = 1'b0, mode_int = 1'b0, two_step = 1'b1;
    logic trouble = 1'b0, fault_clr = 1'b0;
    logic [PER_W-1:0] period = '0;
    logic [N_OUT*CNT_W-1:0] dly = '0, wid = '0;
    logic [N_OUT-1:0] pulse;
    logic busy, done, fault;
    logic [MISS_W-1:0] missed;

    int checks = 0, fails = 0;
    int d [N_OUT];
    int w [N_OUT];
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hvp_pulse_seq #(.N_OUT(N_OUT), .CNT_W(CNT_W), .PER_W(PER_W),
                    .MIN_PERIOD(MIN_P), .MISS_W(MISS_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .trig_ext_i(trig_ext), .mode_int_i(mode_int),
        .period_i(period), .two_step_i(two_step), .dly_i(dly), .wid_i(wid),
        .trouble_i(trouble), .fault_clr_i(fault_clr), .pulse_o(pulse),
        .busy_o(busy), .done_o(done), .fault_o(fault), .missed_o(missed));

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    function automatic bit exp_bit(int i, int k);
        return (i != 6 || two_step) && k >= d[i] && k < d[i] + w[i];
    endfunction

    function automatic int exp_end();
        int e = 0;
        for (int i = 0; i < N_OUT; i++)
            if ((i != 6 || two_step) && w[i] != 0 && d[i] + w[i] > e) e = d[i] + w[i];
        return (e < 1) ? 1 : e;
    endfunction

    task automatic load_cfg();
        for (int i = 0; i < N_OUT; i++) begin
            dly[i*CNT_W +: CNT_W] = CNT_W'(d[i]);
            wid[i*CNT_W +: CNT_W] = CNT_W'(w[i]);
        end
    endtask

    task automatic pulse_trig();
        trig_ext = 1'b1;
        @(negedge clk);
        trig_ext = 1'b0;
    endtask

    // Trigger, then check every cycle k = 0..E (R1, R8)
    task automatic run_set(input string tag);
        int e;
        e = exp_end();
        pulse_trig();
        for (int k = 0; k <= e; k++) begin
            logic [N_OUT-1:0] ex;
            for (int i = 0; i < N_OUT; i++) ex[i] = exp_bit(i, k);
            check({tag, " R1 pulse"}, pulse, ex);
            check("R8 busy", busy, k < e);
            check("R8 done", done, k == e);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_run();
    end

    initial begin
        int seed;
        int m0, t0, t1, t2;
        seed = 32'h5eed;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9 pulse", pulse, 0);
        check("R9 busy", busy, 0);
        check("R9 done", done, 0);
        check("R9 fault", fault, 0);
        check("R9 missed", missed, 0);

        // Directed: staggered lines, two-step on (R1, R2)
        for (int i = 0; i < N_OUT; i++) begin d[i] = i; w[i] = 3; end
        two_step = 1'b1; load_cfg();
        run_set("dir");

        // R4: second step off, its long window must not lengthen the set
        w[6] = 40; two_step = 1'b0; load_cfg();
        run_set("R4");
        check("R4 idle after", busy, 0);

        // R9-style empty set: all widths zero -> E = 1 (R8)
        for (int i = 0; i < N_OUT; i++) w[i] = 0;
        load_cfg();
        run_set("empty");

        // R2: held level starts only one set
        for (int i = 0; i < N_OUT; i++) begin d[i] = 0; w[i] = 2; end
        two_step = 1'b1; load_cfg();
        trig_ext = 1'b1;
        repeat (8) @(negedge clk);
        m0 = 0;
        check("R2 held level no retrigger", busy, 0);
        trig_ext = 1'b0;
        @(negedge clk);
        check("R2 missed unchanged", missed, 0);

        // Random sets (R1, R4, R8)
        for (int n = 0; n < 30; n++) begin
            two_step = 1'($urandom_range(0, 1));
            for (int i = 0; i < N_OUT; i++) begin
                d[i] = $urandom_range(0, 12);
                w[i] = $urandom_range(0, 10);
            end
            load_cfg();
            run_set("rand");
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end

        // R7: trigger while running is counted, not started
        for (int i = 0; i < N_OUT; i++) begin d[i] = 0; w[i] = 20; end
        load_cfg();
        m0 = missed;
        pulse_trig();
        repeat (3) @(negedge clk);
        pulse_trig();
        while (busy || done) @(negedge clk);
        repeat (2) @(negedge clk);
        check("R7 missed incremented", missed, m0 + 1);
        check("R7 no extra set", busy, 0);

        // R5, R6: interlock
        pulse_trig();
        repeat (4) @(negedge clk);
        trouble = 1'b1;
        #1;
        check("R5 pulse forced low", pulse, 0);
        check("R5 busy low", busy, 0);
        @(negedge clk);
        check("R5 fault latched", fault, 1);
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
        check("R6 clear ignored under trouble", fault, 1);
        trouble = 1'b0;
        m0 = missed;
        pulse_trig();
        repeat (25) begin
            check("R5 no done after abort", done, 0);
            @(negedge clk);
        end
        check("R6 fault held", fault, 1);
        check("R6 trigger ignored in fault", busy, 0);
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
        check("R6 fault cleared", fault, 0);
        check("R6 missed unchanged", missed, m0);
        check("R6 idle after clear", busy, 0);

        // R3: internal mode, clamped period, external ignored
        for (int i = 0; i < N_OUT; i++) begin d[i] = 0; w[i] = 3; end
        load_cfg();
        period = PER_W'(10);
        mode_int = 1'b1;
        pulse_trig();
        check("R3 external ignored", busy, 0);
        for (int pass = 0; pass < 2; pass++) begin
            int expp;
            expp = (pass == 0) ? MIN_P : 60;
            t0 = 0; t1 = -1; t2 = -1;
            while (t2 < 0 && t0 < 400) begin
                logic pb;
                pb = busy;
                @(negedge clk);
                t0++;
                if (busy && !pb) begin
                    if (t1 < 0) t1 = t0; else t2 = t0;
                end
            end
            check("R3 internal period", t2 - t1, expp);
            mode_int = 1'b0;
            period = PER_W'(60);
            repeat (5) @(negedge clk);
            mode_int = 1'b1;
        end
        mode_int = 1'b0;
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule